// File: doc/BRIEF.md
# Performance Counter Bank with Global Overflow Flags

This block holds a bank of programmable up-counters. Each counter tracks one event input. One global run register starts or freezes every counter on the same clock edge. Counters that share an event therefore stay equal. Each counter can be preloaded through the register bus. Software sets a sampling period by loading a value near the top of the range. The counter then wraps to zero after the chosen number of events.

A wrap sets that counter's flag in a global overflow status word. Bus writes cannot change that word directly. Software acknowledges flags by writing ones to a separate clear register. A level interrupt stays high while any flag is set whose per-counter interrupt enable is also set. The bus is synchronous. Writes take effect on the clock edge where the write enable is sampled. Read data is registered and appears one cycle after the address is presented.

Top module: `pmc_bank`

## Requirements
- R1: Synchronous reset clears every counter, the run, local-enable and interrupt-enable registers and all overflow flags, and the interrupt output reads 0.
- R2: Counter i adds one on a clock edge only when run bit i, local enable bit i (address 0x03) and event input i are all 1.
- R3: A write to the run register (address 0x00) starts or stops all counters on the same edge. Counters fed by one event keep identical values. With run at 0, no counter moves.
- R4: Counter i is read and written at address 0x10+i, zero-extended on reads. A counter write on an edge takes priority over an increment on that edge.
- R5: A counter that steps from all ones to zero sets overflow bit i of the status word (address 0x01) on that same edge. Bit i belongs to counter i.
- R6: Writes to the status address leave every overflow flag unchanged.
- R7: Writing 1 to bit i of the clear register (address 0x02) clears flag i. Bits written 0 leave their flags as they were. The clear register reads as 0.
- R8: In the run, enable, interrupt-enable and clear registers, bits at or above the counter count are ignored, and they read as 0 where readable.
- R9: If a clear of bit i and a wrap of counter i fall on the same edge, the flag ends up set.
- R10: The interrupt output is high exactly while some flag i is set together with interrupt enable bit i (address 0x04). It stays high until those flags are cleared.
- R11: Read data shows the addressed register one cycle after the address is presented. Unmapped addresses, including counter slots beyond the counter count, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ev | input | NUM_CTR | Per-counter event inputs |
| wr_en | input | 1 | Bus write strobe |
| addr | input | 8 | Bus register address |
| wr_data | input | DATA_W | Bus write data |
| rd_data | output | DATA_W | Registered bus read data |
| irq | output | 1 | Level interrupt for enabled overflow flags |

## Verification
The properties assume that reset is held for at least one clock edge before the first check. They also assume the bus carries at most one write per cycle, so an antecedent like "a write to the status address" excludes a clear in that cycle. The stimulus changes events and bus signals one time unit after a rising edge. It holds reset for several cycles. It keeps events low during register writes except where priority between a write and a count, or between a clear and a wrap, is the subject of the check.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
   localparam int unsigned ADDR_W = 8;
   localparam int unsigned IDX_W  = 4;
   localparam logic [ADDR_W-1:0] A_RUN      = 8'h00;
   localparam logic [ADDR_W-1:0] A_STAT     = 8'h01;
   localparam logic [ADDR_W-1:0] A_CLR      = 8'h02;
   localparam logic [ADDR_W-1:0] A_EN       = 8'h03;
   localparam logic [ADDR_W-1:0] A_IEN      = 8'h04;
   localparam logic [ADDR_W-1:0] A_CNT_BASE = 8'h10;
endpackage

// File: rtl/pmc_counter.sv
module pmc_counter #(
   parameter int unsigned CTR_W = 48
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             inc,
   input  logic             ld,
   input  logic [CTR_W-1:0] ld_val,
   output logic [CTR_W-1:0] cnt,
   output logic             wrap
);
   always_ff @(posedge clk) begin
      if (rst)      cnt <= '0;
      else if (ld)  cnt <= ld_val;
      else if (inc) cnt <= cnt + 1'b1;
   end

   // carry out of the top bit, only when the increment really happens
   assign wrap = inc & ~ld & (&cnt);
endmodule

// File: rtl/pmc_ovf_status.sv
module pmc_ovf_status #(
   parameter int unsigned NUM_CTR = 6
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_CTR-1:0] set_v,
   input  logic               clr_wr,
   input  logic [NUM_CTR-1:0] clr_mask,
   output logic [NUM_CTR-1:0] status
);
   logic [NUM_CTR-1:0] clr_eff;

   assign clr_eff = clr_wr ? clr_mask : '0;

   // set applied after clear so a same-edge wrap wins
   always_ff @(posedge clk) begin
      if (rst) status <= '0;
      else     status <= (status & ~clr_eff) | set_v;
   end
endmodule

// File: rtl/pmc_regfile.sv
module pmc_regfile
   import pmc_pkg::*;
#(
   parameter int unsigned NUM_CTR = 6,
   parameter int unsigned CTR_W   = 48,
   parameter int unsigned DATA_W  = 64
) (
   input  logic                     clk,
   input  logic                     rst,
   input  logic                     wr_en,
   input  logic [ADDR_W-1:0]        addr,
   input  logic [DATA_W-1:0]        wr_data,
   input  logic [NUM_CTR*CTR_W-1:0] cnt_flat,
   input  logic [NUM_CTR-1:0]       status,
   output logic [NUM_CTR-1:0]       run,
   output logic [NUM_CTR-1:0]       en,
   output logic [NUM_CTR-1:0]       ien,
   output logic [NUM_CTR-1:0]       ld,
   output logic [CTR_W-1:0]         ld_val,
   output logic                     clr_wr,
   output logic [NUM_CTR-1:0]       clr_mask,
   output logic [DATA_W-1:0]        rd_data
);
   localparam int unsigned PAD_N = DATA_W - NUM_CTR;

   logic              in_cnt;
   logic [IDX_W-1:0]  idx;
   logic [CTR_W-1:0]  cnt_sel;
   logic              sel_hit;
   logic [DATA_W-1:0] cnt_wide;
   logic [DATA_W-1:0] rd_nxt;

   assign in_cnt   = (addr[ADDR_W-1:IDX_W] == A_CNT_BASE[ADDR_W-1:IDX_W]);
   assign idx      = addr[IDX_W-1:0];
   assign ld_val   = wr_data[CTR_W-1:0];
   assign clr_wr   = wr_en && (addr == A_CLR);
   assign clr_mask = wr_data[NUM_CTR-1:0];

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ld
      assign ld[i] = wr_en && in_cnt && (idx == IDX_W'(i));
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         run <= '0;
         en  <= '0;
         ien <= '0;
      end else if (wr_en) begin
         if (addr == A_RUN) run <= wr_data[NUM_CTR-1:0];
         if (addr == A_EN)  en  <= wr_data[NUM_CTR-1:0];
         if (addr == A_IEN) ien <= wr_data[NUM_CTR-1:0];
      end
   end

   always_comb begin
      cnt_sel = '0;
      sel_hit = 1'b0;
      for (int i = 0; i < NUM_CTR; i++) begin
         if (idx == IDX_W'(i)) begin
            cnt_sel = cnt_flat[i*CTR_W +: CTR_W];
            sel_hit = 1'b1;
         end
      end
   end

   if (CTR_W < DATA_W) begin : g_narrow
      logic wr_hi_unused;
      assign cnt_wide     = {{(DATA_W-CTR_W){1'b0}}, cnt_sel};
      assign wr_hi_unused = ^wr_data[DATA_W-1:CTR_W];
   end else begin : g_full
      assign cnt_wide = cnt_sel;
   end

   always_comb begin
      rd_nxt = '0;
      case (addr)
         A_RUN:   rd_nxt = {{PAD_N{1'b0}}, run};
         A_STAT:  rd_nxt = {{PAD_N{1'b0}}, status};
         A_EN:    rd_nxt = {{PAD_N{1'b0}}, en};
         A_IEN:   rd_nxt = {{PAD_N{1'b0}}, ien};
         default: if (in_cnt && sel_hit) rd_nxt = cnt_wide;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) rd_data <= '0;
      else     rd_data <= rd_nxt;
   end
endmodule

// File: rtl/pmc_bank.sv
module pmc_bank
   import pmc_pkg::*;
#(
   parameter int unsigned NUM_CTR = 6,
   parameter int unsigned CTR_W   = 48,
   parameter int unsigned DATA_W  = 64
) (
   input  logic               clk,
   input  logic               rst,
   input  logic [NUM_CTR-1:0] ev,
   input  logic               wr_en,
   input  logic [ADDR_W-1:0]  addr,
   input  logic [DATA_W-1:0]  wr_data,
   output logic [DATA_W-1:0]  rd_data,
   output logic               irq
);
   localparam int unsigned FLAT_W = NUM_CTR * CTR_W;

   if (NUM_CTR < 1 || NUM_CTR > (1 << IDX_W)) begin : g_bad_num
      $error("pmc_bank: NUM_CTR out of range");
   end
   if (CTR_W < 2 || CTR_W > DATA_W) begin : g_bad_width
      $error("pmc_bank: CTR_W must fit the data bus");
   end
   if (NUM_CTR >= DATA_W) begin : g_bad_bus
      $error("pmc_bank: data bus narrower than flag word");
   end

   logic [NUM_CTR-1:0] run_q, en_q, ien_q, ld_v, wrap_v, clr_mask, status_q;
   logic [CTR_W-1:0]   ld_val;
   logic               clr_wr;
   logic [FLAT_W-1:0]  cnt_flat;

   pmc_regfile #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W), .DATA_W(DATA_W)) regs_i (
      .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr), .wr_data(wr_data),
      .cnt_flat(cnt_flat), .status(status_q), .run(run_q), .en(en_q),
      .ien(ien_q), .ld(ld_v), .ld_val(ld_val), .clr_wr(clr_wr),
      .clr_mask(clr_mask), .rd_data(rd_data)
   );

   for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
      logic inc;
      assign inc = run_q[i] & en_q[i] & ev[i];
      pmc_counter #(.CTR_W(CTR_W)) ctr_i (
         .clk(clk), .rst(rst), .inc(inc), .ld(ld_v[i]), .ld_val(ld_val),
         .cnt(cnt_flat[i*CTR_W +: CTR_W]), .wrap(wrap_v[i])
      );
   end

   pmc_ovf_status #(.NUM_CTR(NUM_CTR)) ovf_i (
      .clk(clk), .rst(rst), .set_v(wrap_v), .clr_wr(clr_wr),
      .clr_mask(clr_mask), .status(status_q)
   );

   assign irq = |(status_q & ien_q);
endmodule

// File: rtl/pmc_bank_chk.sv
module pmc_bank_chk
   import pmc_pkg::*;
#(
   parameter int unsigned NUM_CTR = 6,
   parameter int unsigned CTR_W   = 48
) (
   input logic                     clk,
   input logic                     rst,
   input logic                     wr_en,
   input logic [ADDR_W-1:0]        addr,
   input logic [NUM_CTR-1:0]       clr_bits,
   input logic [NUM_CTR-1:0]       ev,
   input logic [NUM_CTR-1:0]       run,
   input logic [NUM_CTR-1:0]       status,
   input logic [NUM_CTR-1:0]       wrap,
   input logic                     irq,
   input logic [NUM_CTR*CTR_W-1:0] cnt_flat
);
   // R1
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (status == '0 && run == '0 && !irq));

   // R2
   no_event_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (ev == '0 && !wr_en) |=> $stable(cnt_flat));

   // R3
   frozen_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (run == '0 && !wr_en) |=> $stable(cnt_flat));

   // R5 R9
   wrap_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (wrap != '0) |=> ((status & $past(wrap)) == $past(wrap)));

   // R6
   status_ro_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_STAT && wrap == '0) |=> $stable(status));

   // R7
   clear_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (wr_en && addr == A_CLR) |=> ((status & $past(clr_bits & ~wrap)) == '0));

   // R10
   irq_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (irq && !(wr_en && (addr == A_CLR || addr == A_IEN))) |=> irq);
endmodule

bind pmc_bank pmc_bank_chk #(.NUM_CTR(NUM_CTR), .CTR_W(CTR_W)) chk_i (
   .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
   .clr_bits(wr_data[NUM_CTR-1:0]), .ev(ev), .run(run_q),
   .status(status_q), .wrap(wrap_v), .irq(irq), .cnt_flat(cnt_flat)
);

// File: tb/pmc_bank_tb_top.sv
`timescale 1ns/1ps
module pmc_bank_tb_top;
   localparam int N = 6;
   localparam logic [63:0] TOP = 64'h0000_FFFF_FFFF_FFFF;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [N-1:0] ev = '0;
   logic         wr_en = 1'b0;
   logic [7:0]   addr = '0;
   logic [63:0]  wr_data = '0;
   logic [63:0]  rd_data;
   logic         irq;
   logic         rd_req = 1'b0;
   logic         rd_pend = 1'b0;

   int nchk = 0;
   int nfail = 0;
   logic [63:0] exp_q[$];
   string       tag_q[$];

   always #5 clk = ~clk;

   pmc_bank dut_i (
      .clk(clk), .rst(rst), .ev(ev), .wr_en(wr_en), .addr(addr),
      .wr_data(wr_data), .rd_data(rd_data), .irq(irq)
   );

   task automatic chk(string t, logic [63:0] act, logic [63:0] exp);
      nchk++;
      if (act !== exp) begin
         nfail++;
         $display("FAIL %s actual=%h expected=%h", t, act, exp);
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wr(logic [7:0] a, logic [63:0] d);
      addr = a; wr_data = d; wr_en = 1'b1;
      @(posedge clk); #1;
      wr_en = 1'b0;
   endtask

   // driver: presents the address and queues the expected read value
   task automatic rd(logic [7:0] a, logic [63:0] e, string t);
      addr = a; rd_req = 1'b1;
      exp_q.push_back(e); tag_q.push_back(t);
      @(posedge clk); #1;
      rd_req = 1'b0;
   endtask

   task automatic pulse(logic [N-1:0] v, int k);
      ev = v; idle(k); ev = '0;
   endtask

   // monitor: read data is valid in the cycle after the request
   always @(posedge clk) rd_pend <= rd_req;
   always @(negedge clk) begin
      if (rd_pend) begin
         if (exp_q.size() == 0) begin
            nchk++; nfail++;
            $display("FAIL R11 read with no expectation actual=%h expected=none", rd_data);
         end else begin
            chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
         end
      end
   end

   initial begin
      #(200000 * 10);
      nchk++; nfail++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end

   initial begin
      idle(4);
      rst = 1'b0;
      // R1 reset state
      rd(8'h00, 64'h0, "R1 run");
      rd(8'h01, 64'h0, "R1 status");
      rd(8'h04, 64'h0, "R1 ien");
      rd(8'h10, 64'h0, "R1 cnt0");
      rd(8'h15, 64'h0, "R1 cnt5");
      @(negedge clk); chk("R1 irq", {63'h0, irq}, 64'h0);
      // R8 bits above the counter count
      wr(8'h00, '1);
      rd(8'h00, 64'h3F, "R8 run mask");
      wr(8'h03, '1);
      rd(8'h03, 64'h3F, "R8 enable mask");
      wr(8'h00, 64'h0);
      // R2 gating: run off, events high
      ev = '1; idle(4); ev = '0;
      rd(8'h10, 64'h0, "R2 run off");
      wr(8'h00, 64'h3F);
      pulse(6'b000100, 5);
      rd(8'h12, 64'd5, "R2 counting");
      wr(8'h03, 64'h37);
      pulse(6'b001000, 4);
      rd(8'h13, 64'd0, "R2 local enable off");
      rd(8'h12, 64'd5, "R2 neighbour unchanged");
      // R4 load and priority over increment
      wr(8'h14, 64'h1234);
      rd(8'h14, 64'h1234, "R4 readback");
      ev = 6'b010000;
      wr(8'h14, 64'd100);
      ev = '0;
      rd(8'h14, 64'd100, "R4 write beats increment");
      // R3 global start/stop
      wr(8'h00, 64'h0);
      wr(8'h10, 64'h0);
      wr(8'h11, 64'h0);
      ev = 6'b000011;
      wr(8'h00, 64'h3F);
      idle(5);
      wr(8'h00, 64'h0);
      ev = '0;
      rd(8'h10, 64'd6, "R3 cnt0");
      rd(8'h11, 64'd6, "R3 cnt1 equal");
      pulse(6'b000011, 3);
      rd(8'h10, 64'd6, "R3 frozen");
      // R5 wrap sets flag
      wr(8'h00, 64'h3F);
      wr(8'h03, 64'h3F);
      wr(8'h10, TOP - 64'd2);
      pulse(6'b000001, 2);
      rd(8'h10, TOP, "R5 at all ones");
      rd(8'h01, 64'h0, "R5 no flag yet");
      pulse(6'b000001, 1);
      rd(8'h01, 64'h01, "R5 flag bit0");
      rd(8'h10, 64'h0, "R5 wrapped to zero");
      // R10 interrupt
      @(negedge clk); chk("R10 irq masked", {63'h0, irq}, 64'h0);
      wr(8'h04, 64'h01);
      @(negedge clk); chk("R10 irq raised", {63'h0, irq}, 64'h1);
      idle(3);
      @(negedge clk); chk("R10 irq held", {63'h0, irq}, 64'h1);
      // R6 status is read-only
      wr(8'h01, 64'h0);
      rd(8'h01, 64'h01, "R6 write zeros ignored");
      // R7 clear
      wr(8'h02, 64'h3E);
      rd(8'h01, 64'h01, "R7 zero bits keep flag");
      wr(8'h02, 64'h01);
      rd(8'h01, 64'h0, "R7 flag cleared");
      @(negedge clk); chk("R10 irq dropped", {63'h0, irq}, 64'h0);
      rd(8'h02, 64'h0, "R7 clear reads zero");
      wr(8'h01, '1);
      rd(8'h01, 64'h0, "R6 write ones ignored");
      // R9 set wins over clear
      wr(8'h11, TOP);
      ev = 6'b000010;
      wr(8'h02, 64'h02);
      ev = '0;
      rd(8'h01, 64'h02, "R9 set wins");
      rd(8'h11, 64'h0, "R9 counter wrapped");
      // R11 unmapped addresses
      rd(8'h3F, 64'h0, "R11 unmapped");
      rd(8'h16, 64'h0, "R11 slot beyond count");
      idle(3);
      $display("%0d/%0d checks passed", nchk - nfail, nchk);
      $finish;
   end
endmodule